// File: doc/BRIEF.md
# Clock-Sweep Not-Recently-Used Victim Selector

This block chooses which of `NUM_FRAMES` physical frames should be given up when a new page must be brought in. It keeps one reference flag and one dirty flag for every frame, plus a circular hand that stays on the most recent victim. Each access to a frame is reported on the mark port. A read sets the frame's reference flag. A write sets the reference flag and also the dirty flag.

When a victim is requested, the hand walks forward one frame per clock, wrapping at the end of the table. Each frame it passes over loses its reference flag. The walk stops on the first frame whose reference flag is clear. An optional clean-first mode also skips dirty frames during the first full lap. If that lap finds nothing, the walk takes the first unreferenced frame, dirty or not. The chosen frame's dirty flag is cleared, because the frame is handed over for refill. Page-table contents, page loading and writeback are handled elsewhere.

Top module: `nru_clock_replacer`

## Requirements
- R1: After reset, `req_ready_o` is 1, `done_o` is 0, every reference and dirty flag is 0, and the hand sits on frame `NUM_FRAMES-1`, so the first search examines frame 0 first.
- R2: A cycle with `mark_valid_i`=1 sets the reference flag of frame `mark_idx_i`. If `mark_write_i`=1 as well, the dirty flag of that frame is also set.
- R3: A request is accepted on a clock edge where both `req_valid_i` and `req_ready_o` are 1. `req_ready_o` is 0 from the cycle after acceptance until `done_o` rises. `done_o` is high for exactly one cycle, and `victim_o` holds the chosen frame index in that cycle.
- R4: A search examines one frame per clock, starting at (hand+1) mod `NUM_FRAMES` and wrapping to 0 after the last frame. If the victim is the k-th frame examined, `done_o` is 1 in the k-th cycle after the acceptance edge.
- R5: With `prefer_clean_i`=0, the victim is the first examined frame whose reference flag is 0, whether or not it is dirty.
- R6: Every frame the search examines and does not choose has its reference flag cleared.
- R7: The hand is left on the victim, and the next search starts at the frame after it.
- R8: With `prefer_clean_i`=1 (sampled at acceptance), during the first `NUM_FRAMES` examinations a frame is chosen only if both its reference and dirty flags are 0.
- R9: In clean-first mode, once `NUM_FRAMES` frames have been examined without a choice, the search takes the next frame whose reference flag is 0, even if it is dirty.
- R10: The dirty flag of the chosen frame is cleared when it is chosen.
- R11: If a mark and a search clear hit the same frame in the same cycle, the mark wins and the reference flag ends up 1.
- R12: With no marks during the search, a search finishes within `NUM_FRAMES+1` examinations in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mark_valid_i | input | 1 | Report an access to one frame |
| mark_idx_i | input | $clog2(NUM_FRAMES) | Frame that was accessed |
| mark_write_i | input | 1 | Access was a write; also set the dirty flag |
| req_valid_i | input | 1 | Request a victim search |
| prefer_clean_i | input | 1 | 1 selects clean-first search |
| req_ready_o | output | 1 | Idle and able to accept a request |
| done_o | output | 1 | One-cycle pulse: search finished |
| victim_o | output | $clog2(NUM_FRAMES) | Chosen frame index |

## Verification
A mark takes effect at the edge that samples it, and the next search's choice shows the result. A search result is due k cycles after the acceptance edge, where k is the number of frames examined. The bench counts clock edges from acceptance and compares that count exactly with the examination count from its own flag-and-hand model. It also requires `req_ready_o` to stay low in every earlier cycle and `done_o` to drop in the cycle after. All outputs are sampled on the falling clock edge. For the mark-versus-clear race, the mark is held across the very edge on which the first examined frame is cleared. In that case the expected victim and latency differ by one frame and one cycle from the outcome where the clear wins.

// File: rtl/nru_pkg.sv
package nru_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/nru_flag_array.sv
module nru_flag_array #(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mark_valid_i,
  input  logic [IDX_W-1:0]      mark_idx_i,
  input  logic                  mark_write_i,
  input  logic                  clr_ref_en_i,
  input  logic [IDX_W-1:0]      clr_ref_idx_i,
  input  logic                  clr_dirty_en_i,
  input  logic [IDX_W-1:0]      clr_dirty_idx_i,
  output logic [NUM_FRAMES-1:0] ref_o,
  output logic [NUM_FRAMES-1:0] dirty_o
);

  logic [NUM_FRAMES-1:0] ref_q;
  logic [NUM_FRAMES-1:0] dirty_q;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    logic mark_hit, clr_ref_hit, clr_dirty_hit;
    assign mark_hit      = mark_valid_i   && (mark_idx_i      == IDX_W'(g));
    assign clr_ref_hit   = clr_ref_en_i   && (clr_ref_idx_i   == IDX_W'(g));
    assign clr_dirty_hit = clr_dirty_en_i && (clr_dirty_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ref_q[g]   <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else begin
        // mark has priority over the sweep clear
        if (mark_hit)         ref_q[g] <= 1'b1;
        else if (clr_ref_hit) ref_q[g] <= 1'b0;
        if (mark_hit && mark_write_i) dirty_q[g] <= 1'b1;
        else if (clr_dirty_hit)       dirty_q[g] <= 1'b0;
      end
    end
  end

  assign ref_o   = ref_q;
  assign dirty_o = dirty_q;

  assert_mark_sets_ref_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_valid_i |=> ref_q[$past(mark_idx_i)]);

  assert_write_sets_dirty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_valid_i && mark_write_i) |=> dirty_q[$past(mark_idx_i)]);

  assert_mark_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_valid_i && clr_ref_en_i && (mark_idx_i == clr_ref_idx_i)) |=> ref_q[$past(clr_ref_idx_i)]);

  assert_pass_clears_ref_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ref_en_i && !(mark_valid_i && (mark_idx_i == clr_ref_idx_i)))
      |=> !ref_q[$past(clr_ref_idx_i)]);

  assert_victim_dirty_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_dirty_en_i && !(mark_valid_i && mark_write_i && (mark_idx_i == clr_dirty_idx_i)))
      |=> !dirty_q[$past(clr_dirty_idx_i)]);

endmodule

// File: rtl/nru_sweep_ctrl.sv
module nru_sweep_ctrl
  import nru_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  prefer_clean_i,
  input  logic [NUM_FRAMES-1:0] ref_i,
  input  logic [NUM_FRAMES-1:0] dirty_i,
  output logic                  req_ready_o,
  output logic                  done_o,
  output logic [IDX_W-1:0]      victim_o,
  output logic                  clr_ref_en_o,
  output logic                  clr_dirty_en_o,
  output logic [IDX_W-1:0]      cur_idx_o
);

  localparam int CNT_W = IDX_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);
  localparam logic [CNT_W-1:0] SWEEP    = CNT_W'(NUM_FRAMES);

  scan_state_e      state_q;
  logic [IDX_W-1:0] hand_q, cur_q, victim_q;
  logic [CNT_W-1:0] cnt_q;
  logic             clean_q, done_q;
  logic             scanning, clean_phase, hit;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] x);
    return (x == LAST_IDX) ? '0 : x + 1'b1;
  endfunction

  assign scanning    = (state_q == ST_SCAN);
  assign clean_phase = clean_q && (cnt_q < SWEEP);
  assign hit         = scanning && !ref_i[cur_q] && !(clean_phase && dirty_i[cur_q]);

  assign clr_ref_en_o   = scanning && !hit;
  assign clr_dirty_en_o = hit;
  assign cur_idx_o      = cur_q;
  assign req_ready_o    = !scanning;
  assign done_o         = done_q;
  assign victim_o       = victim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      hand_q   <= LAST_IDX;
      cur_q    <= '0;
      cnt_q    <= '0;
      clean_q  <= 1'b0;
      done_q   <= 1'b0;
      victim_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          state_q <= ST_SCAN;
          cur_q   <= step(hand_q);
          cnt_q   <= '0;
          clean_q <= prefer_clean_i;
        end
        ST_SCAN: if (hit) begin
          state_q  <= ST_IDLE;
          hand_q   <= cur_q;
          victim_q <= cur_q;
          done_q   <= 1'b1;
        end else begin
          cur_q <= step(cur_q);
          if (cnt_q < SWEEP) cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_after_accept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_ready_on_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);

  assert_victim_unreferenced_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_dirty_en_o |-> !ref_i[cur_idx_o]);

endmodule

// File: rtl/nru_clock_replacer.sv
module nru_clock_replacer #(
  parameter int NUM_FRAMES = 8,
  parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mark_valid_i,
  input  logic [IDX_W-1:0] mark_idx_i,
  input  logic             mark_write_i,
  input  logic             req_valid_i,
  input  logic             prefer_clean_i,
  output logic             req_ready_o,
  output logic             done_o,
  output logic [IDX_W-1:0] victim_o
);

  logic [NUM_FRAMES-1:0] ref_vec, dirty_vec;
  logic                  clr_ref_en, clr_dirty_en;
  logic [IDX_W-1:0]      cur_idx;

  nru_flag_array #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_flags (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .mark_valid_i    (mark_valid_i),
    .mark_idx_i      (mark_idx_i),
    .mark_write_i    (mark_write_i),
    .clr_ref_en_i    (clr_ref_en),
    .clr_ref_idx_i   (cur_idx),
    .clr_dirty_en_i  (clr_dirty_en),
    .clr_dirty_idx_i (cur_idx),
    .ref_o           (ref_vec),
    .dirty_o         (dirty_vec)
  );

  nru_sweep_ctrl #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .prefer_clean_i (prefer_clean_i),
    .ref_i          (ref_vec),
    .dirty_i        (dirty_vec),
    .req_ready_o    (req_ready_o),
    .done_o         (done_o),
    .victim_o       (victim_o),
    .clr_ref_en_o   (clr_ref_en),
    .clr_dirty_en_o (clr_dirty_en),
    .cur_idx_o      (cur_idx)
  );

endmodule

// File: tb/nru_clock_replacer_bench.sv
`timescale 1ns/1ps
module nru_clock_replacer_bench;
  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mark_valid_i = 1'b0;
  logic [IW-1:0] mark_idx_i = '0;
  logic          mark_write_i = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          prefer_clean_i = 1'b0;
  logic          req_ready_o, done_o;
  logic [IW-1:0] victim_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model of the flags and hand
  bit [N-1:0] m_ref   = '0;
  bit [N-1:0] m_dirty = '0;
  int         m_hand  = N - 1;

  always #2.5 clk = ~clk;

  nru_clock_replacer #(.NUM_FRAMES(N)) u_nru_clock_replacer (
    .clk_i(clk), .rst_ni(rst_ni),
    .mark_valid_i(mark_valid_i), .mark_idx_i(mark_idx_i), .mark_write_i(mark_write_i),
    .req_valid_i(req_valid_i), .prefer_clean_i(prefer_clean_i),
    .req_ready_o(req_ready_o), .done_o(done_o), .victim_o(victim_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic mark(input int idx, input bit wr);
    @(negedge clk);
    mark_valid_i = 1'b1;
    mark_idx_i   = IW'(idx);
    mark_write_i = wr;
    @(negedge clk);
    mark_valid_i = 1'b0;
    mark_write_i = 1'b0;
    m_ref[idx] = 1'b1;
    if (wr) m_dirty[idx] = 1'b1;
  endtask

  task automatic mark_all(input bit wr);
    for (int i = 0; i < N; i++) mark(i, wr);
  endtask

  // model search: a mark on mk_idx lands at the edge of the first examination
  task automatic model_search(input bit clean, input bit mk, input int mk_idx,
                              output int vic, output int exam);
    int p = m_hand;
    int cnt = 0;
    vic = -1;
    exam = 0;
    while (vic < 0 && cnt < 4 * N) begin
      bit fallback;
      p = (p + 1) % N;
      fallback = !clean || (cnt >= N);
      if (!m_ref[p] && (fallback || !m_dirty[p])) begin
        vic = p;
        m_dirty[p] = 1'b0;
      end else begin
        m_ref[p] = 1'b0;
      end
      if (cnt == 0 && mk) m_ref[mk_idx] = 1'b1;
      cnt++;
    end
    exam = cnt;
    m_hand = vic;
  endtask

  task automatic do_search(input bit clean, input bit mk, input int mk_idx, input string tag);
    int exp_v, exp_c, cycles;
    bit busy_ok = 1'b1;
    model_search(clean, mk, mk_idx, exp_v, exp_c);
    @(negedge clk);
    check(req_ready_o == 1'b1, {tag, " R3 ready before request"}, int'(req_ready_o), 1);
    req_valid_i    = 1'b1;
    prefer_clean_i = clean;
    @(negedge clk);
    req_valid_i = 1'b0;
    if (mk) begin
      mark_valid_i = 1'b1;
      mark_idx_i   = IW'(mk_idx);
      mark_write_i = 1'b0;
    end
    cycles = 0;
    while (cycles < 4 * N) begin
      @(posedge clk);
      @(negedge clk);
      mark_valid_i = 1'b0;
      cycles++;
      if (done_o) break;
      if (req_ready_o) busy_ok = 1'b0;
    end
    check(done_o == 1'b1, {tag, " R3 done seen"}, int'(done_o), 1);
    check(cycles == exp_c, {tag, " R4 R12 latency"}, cycles, exp_c);
    check(int'(victim_o) == exp_v, {tag, " victim"}, int'(victim_o), exp_v);
    check(busy_ok, {tag, " R3 ready low while busy"}, int'(busy_ok), 1);
    @(negedge clk);
    check(done_o == 1'b0, {tag, " R3 done one cycle"}, int'(done_o), 0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check(req_ready_o == 1'b1, "R1 ready after reset", int'(req_ready_o), 1);
    check(done_o == 1'b0, "R1 done low after reset", int'(done_o), 0);
    rst_ni = 1'b1;
    do_search(1'b0, 1'b0, 0, "R1 first search picks frame 0");
  endtask

  task automatic t_persist();
    do_search(1'b0, 1'b0, 0, "R7 hand persists");
  endtask

  task automatic t_pass_clear();
    mark(2, 1'b0);
    mark(3, 1'b0);
    do_search(1'b0, 1'b0, 0, "R2 R6 skip marked frames");
    for (int i = 5; i < N; i++) mark(i, 1'b0);
    mark(0, 1'b0);
    mark(1, 1'b0);
    do_search(1'b0, 1'b0, 0, "R6 passed flags cleared");
  endtask

  task automatic t_plain_dirty();
    mark(3, 1'b1);
    do_search(1'b0, 1'b0, 0, "R2 write mark skipped");
    for (int i = 5; i < N; i++) mark(i, 1'b0);
    for (int i = 0; i < 3; i++) mark(i, 1'b0);
    do_search(1'b0, 1'b0, 0, "R5 plain takes dirty frame");
  endtask

  task automatic t_clean_pref();
    mark(4, 1'b1);
    mark(5, 1'b1);
    do_search(1'b0, 1'b0, 0, "R6 clear dirty refs");
    mark(7, 1'b1);
    mark(0, 1'b1);
    do_search(1'b0, 1'b0, 0, "R5 plain pick");
    mark(2, 1'b0);
    mark(3, 1'b0);
    do_search(1'b1, 1'b0, 0, "R8 clean skips dirty");
  endtask

  task automatic t_fallback();
    mark_all(1'b1);
    do_search(1'b1, 1'b0, 0, "R9 R12 fallback to dirty");
    do_search(1'b1, 1'b0, 0, "R10 victim dirty cleared");
  endtask

  task automatic t_mark_race();
    mark_all(1'b0);
    do_search(1'b0, 1'b0, 0, "R12 plain full lap");
    mark_all(1'b0);
    do_search(1'b0, 1'b1, (m_hand + 1) % N, "R11 mark beats clear");
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_persist();
    t_pass_clear();
    t_plain_dirty();
    t_clean_pref();
    t_fallback();
    t_mark_race();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule